// File: doc/BRIEF.md
# UART Status and Baud Tick Source Selector

This block is the status and clock-selection register of a simple UART, together with the logic around it. It keeps three sticky error flags: a frame error, a receive overrun and a transmit collision. The receiver and transmitter set these flags through event inputs, and software clears them by writing the register. The flags are status only and raise no interrupt.

The same register holds a halving control and two independent 2-bit selectors. Each selector picks one of four timer overflow pulses as the source for the baud tick of one direction. When halving is enabled, a toggle flip-flop per direction passes only every second selected overflow. The register port is a plain 8-bit write strobe with data, plus a continuous read value. The shift registers and the timers sit outside the block.

Top module: `ustat_sel_top`

## Requirements
- R1: After reset the register reads 0x00 and both tick outputs are low.
- R2: Bit 7 (frame error) is set one cycle after a cycle with `stopSampleValid`=1 and `stopSampleBit`=0. A valid stop sample of 1 leaves it unchanged.
- R3: Bit 6 (receive overrun) is set when `rxByteLatched` arrives while the previous byte is still unread. A byte counts as unread from its `rxByteLatched` until an `rxBufRead`. A read in the same cycle as a latch consumes the older byte.
- R4: Bit 5 (transmit collision) is set when `txBufWrite` occurs while `txBusy`=1. A write while `txBusy`=0 leaves it clear.
- R5: The error flags in bits 7:5 are sticky. A register write with 0 in a flag's bit clears that flag, and a write with 1 leaves it as it was.
- R6: If a flag-setting event and a clearing write of the same flag fall in the same cycle, the flag is set after that cycle.
- R7: Bit 4 controls halving. With bit 4 = 0, each direction's tick passes every second selected overflow, starting with the second. With bit 4 = 1, every selected overflow produces a tick.
- R8: Bits 3:2 select the transmit source: 00 `tmrOvf[0]`, 01 `tmrOvf[1]`, 10 `tmrOvf[2]`, 11 `tmrOvf[3]`. Overflows of unselected sources produce no transmit tick.
- R9: Bits 1:0 select the receive source with the same encoding, independently of bits 3:2.
- R10: A write that changes a direction's selector field clears that direction's halving toggle, so the next selected overflow after the write produces no tick while halving is on.
- R11: Each tick is a one-cycle pulse, high in the cycle after the cycle in which its selected overflow input was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Current register value |
| tmrOvf | input | 4 | Timer overflow pulses, index = selector code |
| stopSampleValid | input | 1 | Stop bit sample is valid this cycle |
| stopSampleBit | input | 1 | Sampled stop bit value |
| rxByteLatched | input | 1 | Receiver latched a new byte into its buffer |
| rxBufRead | input | 1 | Software read the receive buffer |
| txBufWrite | input | 1 | Software wrote the transmit buffer |
| txBusy | input | 1 | Transmission in progress |
| txTick | output | 1 | Transmit baud tick |
| rxTick | output | 1 | Receive baud tick |

## Verification
Every result is due exactly one clock edge after its stimulus. A flag event or a register write shows up in `regRdData` after the edge that samples it, and a selected overflow shows up on its tick output after the edge that samples it. The bench drives inputs just after a rising edge and waits one edge. It samples outputs 1 ns after that edge, and for ticks it checks again one cycle later to confirm that the pulse is single. Halving sequences are checked pulse by pulse, so that each overflow is matched with the tick it should or should not produce.

// File: rtl/ustat_pkg.sv
package ustat_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int NUM_DIR = 2;
  localparam int TX_DIR  = 0;
  localparam int RX_DIR  = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic setFrame;
    logic setOverrun;
    logic setCollision;
    logic clrFrame;
    logic clrOverrun;
    logic clrCollision;
    logic cfgWrite;
    logic [NUM_DIR-1:0] selChange;
  } ctlStrobes_t;
endpackage

// File: rtl/ustat_tickgen.sv
module ustat_tickgen
  import ustat_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] ovf,
  input  logic [SW-1:0]   sel,
  input  logic            halveOff,
  input  logic            clrToggle,
  output logic            tick
);
  logic toggleQ;
  logic selPulse;

  assign selPulse = ovf[sel];

  always_ff @(posedge clk) begin
    if (!rstN || clrToggle) begin
      toggleQ <= 1'b0;
      tick    <= 1'b0;
    end else begin
      if (halveOff) begin
        tick <= selPulse;
      end else begin
        tick <= selPulse & toggleQ;
        if (selPulse) toggleQ <= ~toggleQ;
      end
    end
  end
endmodule

// File: rtl/ustat_ctrl.sv
module ustat_ctrl
  import ustat_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [REG_W-1:0]         regWrData,
  input  logic [NUM_DIR*SEL_W-1:0] curSel,
  input  logic                     stopSampleValid,
  input  logic                     stopSampleBit,
  input  logic                     rxByteLatched,
  input  logic                     rxBufRead,
  input  logic                     txBufWrite,
  input  logic                     txBusy,
  output ctlStrobes_t              strb
);
  logic rxUnread;

  always_ff @(posedge clk) begin
    if (!rstN) rxUnread <= 1'b0;
    else if (rxByteLatched) rxUnread <= 1'b1;
    else if (rxBufRead) rxUnread <= 1'b0;
  end

  always_comb begin
    strb              = '0;
    strb.setFrame     = stopSampleValid & ~stopSampleBit;
    strb.setOverrun   = rxByteLatched & rxUnread & ~rxBufRead;
    strb.setCollision = txBufWrite & txBusy;
    strb.clrFrame     = regWrEn & ~regWrData[7];
    strb.clrOverrun   = regWrEn & ~regWrData[6];
    strb.clrCollision = regWrEn & ~regWrData[5];
    strb.cfgWrite     = regWrEn;
    // selector field of direction d sits at bits [(NUM_DIR-d)*SEL_W-1 -: SEL_W]
    for (int d = 0; d < NUM_DIR; d++) begin
      strb.selChange[d] = regWrEn &
        (regWrData[(NUM_DIR-d)*SEL_W-1 -: SEL_W] != curSel[(NUM_DIR-d)*SEL_W-1 -: SEL_W]);
    end
  end
endmodule

// File: rtl/ustat_dp.sv
module ustat_dp
  import ustat_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strb,
  input  logic [REG_W-1:0]         regWrData,
  input  logic [NUM_SRC-1:0]       tmrOvf,
  output logic [NUM_DIR*SEL_W-1:0] curSel,
  output logic [REG_W-1:0]         regRdData,
  output logic [NUM_DIR-1:0]       ticks
);
  localparam int CFG_W = NUM_DIR*SEL_W + 1;

  logic frameQ, overrunQ, collisionQ;
  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ     <= 1'b0;
      overrunQ   <= 1'b0;
      collisionQ <= 1'b0;
      cfgQ       <= '0;
    end else begin
      if (strb.setFrame)          frameQ <= 1'b1;
      else if (strb.clrFrame)     frameQ <= 1'b0;
      if (strb.setOverrun)        overrunQ <= 1'b1;
      else if (strb.clrOverrun)   overrunQ <= 1'b0;
      if (strb.setCollision)      collisionQ <= 1'b1;
      else if (strb.clrCollision) collisionQ <= 1'b0;
      if (strb.cfgWrite)          cfgQ <= regWrData[CFG_W-1:0];
    end
  end

  assign curSel    = cfgQ[NUM_DIR*SEL_W-1:0];
  assign regRdData = {frameQ, overrunQ, collisionQ, cfgQ};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    ustat_tickgen #(.NSRC(NUM_SRC)) tick_i (
      .clk      (clk),
      .rstN     (rstN),
      .ovf      (tmrOvf),
      .sel      (cfgQ[(NUM_DIR-d)*SEL_W-1 -: SEL_W]),
      .halveOff (cfgQ[CFG_W-1]),
      .clrToggle(strb.selChange[d]),
      .tick     (ticks[d])
    );
  end
endmodule

// File: rtl/ustat_sel_top.sv
module ustat_sel_top
  import ustat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [NUM_SRC-1:0] tmrOvf,
  input  logic               stopSampleValid,
  input  logic               stopSampleBit,
  input  logic               rxByteLatched,
  input  logic               rxBufRead,
  input  logic               txBufWrite,
  input  logic               txBusy,
  output logic               txTick,
  output logic               rxTick
);
  ctlStrobes_t strb;
  logic [NUM_DIR*SEL_W-1:0] curSel;
  logic [NUM_DIR-1:0] ticks;

  ustat_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .curSel(curSel), .stopSampleValid(stopSampleValid),
    .stopSampleBit(stopSampleBit), .rxByteLatched(rxByteLatched),
    .rxBufRead(rxBufRead), .txBufWrite(txBufWrite), .txBusy(txBusy),
    .strb(strb)
  );

  ustat_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .tmrOvf(tmrOvf), .curSel(curSel), .regRdData(regRdData), .ticks(ticks)
  );

  assign txTick = ticks[TX_DIR];
  assign rxTick = ticks[RX_DIR];
endmodule

// File: rtl/ustat_sel_chk.sv
module ustat_sel_chk
  import ustat_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [REG_W-1:0]   regWrData,
  input logic [REG_W-1:0]   regRdData,
  input logic [NUM_SRC-1:0] tmrOvf,
  input logic               stopSampleValid,
  input logic               stopSampleBit,
  input logic               txBufWrite,
  input logic               txBusy,
  input logic               txTick,
  input logic               rxTick
);
  // R2
  frame_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSampleValid && !stopSampleBit |=> regRdData[7]);
  // R4
  collision_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBufWrite && txBusy |=> regRdData[5]);
  // R5
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7] && !(regWrEn && !regWrData[7]) |=> regRdData[7]);
  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[6] && !(regWrEn && !regWrData[6]) |=> regRdData[6]);
  // R11
  tx_tick_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick |-> $past(tmrOvf) != '0);
  // R11
  rx_tick_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |-> $past(tmrOvf) != '0);
  // R7
  tx_halve_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick && $past(txTick) |-> $past(regRdData[4]));
endmodule

bind ustat_sel_top ustat_sel_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .tmrOvf(tmrOvf), .stopSampleValid(stopSampleValid),
  .stopSampleBit(stopSampleBit), .txBufWrite(txBufWrite), .txBusy(txBusy),
  .txTick(txTick), .rxTick(rxTick)
);

// File: tb/ustat_sel_top_tb.sv
`timescale 1ns/1ps
module ustat_sel_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [3:0] tmrOvf = '0;
  logic stopSampleValid = 1'b0, stopSampleBit = 1'b1;
  logic rxByteLatched = 1'b0, rxBufRead = 1'b0;
  logic txBufWrite = 1'b0, txBusy = 1'b0;
  logic txTick, rxTick;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ustat_sel_top dut_i (.*);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; cyc(); regWrEn = 1'b0;
  endtask

  // one overflow pulse, then check both ticks and that they drop next cycle
  task automatic pulse(input logic [3:0] m, input bit expTx, input bit expRx, input string req);
    tmrOvf = m; cyc(); tmrOvf = '0;
    chk({req, " txTick"}, txTick, expTx);
    chk({req, " rxTick"}, rxTick, expRx);
    cyc();
    chk("R11 txTick single", txTick, 0);
    chk("R11 rxTick single", rxTick, 0);
  endtask

  task automatic t_reset();
    chk("R1 reg", regRdData, 8'h00);
    chk("R1 txTick", txTick, 0);
    chk("R1 rxTick", rxTick, 0);
  endtask

  task automatic t_frame();
    stopSampleValid = 1'b1; stopSampleBit = 1'b1; cyc();
    chk("R2 good stop", regRdData[7], 0);
    stopSampleBit = 1'b0; cyc(); stopSampleValid = 1'b0; stopSampleBit = 1'b1;
    chk("R2 bad stop", regRdData[7], 1);
    wr(8'hE0);
    chk("R5 write 1 keeps", regRdData[7], 1);
    wr(8'h00);
    chk("R5 write 0 clears", regRdData[7], 0);
  endtask

  task automatic t_overrun();
    rxByteLatched = 1'b1; cyc(); rxByteLatched = 1'b0;
    chk("R3 first byte", regRdData[6], 0);
    rxBufRead = 1'b1; rxByteLatched = 1'b1; cyc(); rxBufRead = 1'b0;
    chk("R3 read+latch", regRdData[6], 0);
    cyc();
    chk("R3 unread again", regRdData[6], 1);
    rxByteLatched = 1'b0;
    wr(8'h00);
    chk("R5 overrun clear", regRdData[6], 0);
  endtask

  task automatic t_collision();
    txBufWrite = 1'b1; txBusy = 1'b0; cyc();
    chk("R4 idle write", regRdData[5], 0);
    txBusy = 1'b1; cyc(); txBufWrite = 1'b0; txBusy = 1'b0;
    chk("R4 busy write", regRdData[5], 1);
    wr(8'h00);
    chk("R5 collision clear", regRdData[5], 0);
  endtask

  task automatic t_race();
    stopSampleValid = 1'b1; stopSampleBit = 1'b0;
    regWrEn = 1'b1; regWrData = 8'h00; cyc();
    regWrEn = 1'b0; stopSampleValid = 1'b0; stopSampleBit = 1'b1;
    chk("R6 event beats clear", regRdData[7], 1);
    wr(8'h00);
  endtask

  task automatic t_select();
    wr(8'h10 | (2 << 2) | 1);   // no halving, tx=src2, rx=src1
    chk("R8/R9 cfg readback", regRdData, 8'h19);
    pulse(4'b0100, 1, 0, "R8 tx src2");
    pulse(4'b0010, 0, 1, "R9 rx src1");
    pulse(4'b0001, 0, 0, "R8 unselected src0");
    pulse(4'b0110, 1, 1, "R9 both");
  endtask

  task automatic t_halve();
    wr((3 << 2) | 0);           // halving on, tx=src3, rx=src0
    pulse(4'b1000, 0, 0, "R7 tx first");
    pulse(4'b1000, 1, 0, "R7 tx second");
    pulse(4'b1000, 0, 0, "R7 tx third");
    pulse(4'b1001, 1, 0, "R7 tx fourth rx first");
    pulse(4'b0001, 0, 1, "R7 rx second");
  endtask

  task automatic t_selchg();
    wr(3 << 2);                 // same selectors, halving on
    pulse(4'b1000, 0, 0, "R10 prime");
    wr(2 << 2);                 // tx selector changes, toggle cleared
    pulse(4'b0100, 0, 0, "R10 after change");
    pulse(4'b0100, 1, 0, "R10 second after change");
  endtask

  initial begin
    #1;
    t_reset();
    cyc(); cyc(); rstN = 1'b1;
    t_reset();
    t_frame();
    t_overrun();
    t_collision();
    t_race();
    t_select();
    t_halve();
    t_selchg();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule